// File: doc/BRIEF.md
# IPv4 Forwarding Decision Engine

This block makes the per-packet forwarding decision for an IPv4 router data path. A 20-byte header is presented as one 160-bit vector together with the length of the whole frame, under a valid/ready handshake. One cycle after the header is accepted, the block returns a registered verdict: forward, drop, or hand to the CPU exception path. The verdict is held until the consumer takes it.

The block checks header integrity and format, then enforces the length and hop-limit policy. It then searches an eight-entry route table by longest prefix on the destination address. Software fills the table through a plain write port. Each entry holds a prefix, a mask, a next-hop address, a port bitmap and a valid flag.

On a forward verdict the block presents the chosen port bitmap and next hop. It also presents the rewritten header, with the hop count lowered by one and the checksum patched incrementally, so the header still verifies downstream.

Top module: `ipv4_fwd_engine`

## Requirements
- R1: A header accepted on a clock edge where `in_valid` and `in_ready` are both high appears on the outputs with `out_valid` high after exactly that edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: The checksum check forms the ones'-complement sum of the ten 16-bit header words, including the checksum field at bits [79:64]. If that sum is not 0xFFFF, the verdict is drop (code 2'b01). This check outranks every other rule.
- R3: The frame length is checked only when the checksum verifies. If `in_frame_len` is below 64 or above 1500, the verdict is drop (2'b01).
- R4: A header whose version field (bits [159:156]) is not 4, or whose header length field (bits [155:152]) is not 5, gets the CPU verdict (2'b10). This applies only when neither drop rule applies.
- R5: A header whose TTL (bits [95:88]) is 0 or 1 gets the CPU verdict (2'b10). This applies only when none of the rules above applies.
- R6: The route is taken from the valid entry whose mask has the most one bits, among the entries where `dst & mask == prefix & mask`. The destination is bits [31:0]. When two entries have equal mask length, the lower index wins.
- R7: An entry with an all-zero mask matches every destination and serves as the default route. A packet that passes all the checks but matches no valid entry gets the CPU verdict (2'b10).
- R8: On forward (2'b00), `out_ports` and `out_next_hop` come from the chosen entry. `out_hdr` equals the input header with TTL lowered by one and the checksum field replaced so that the header verifies again. All other fields are unchanged.
- R9: On drop or CPU, `out_ports` and `out_next_hop` are zero and `out_hdr` equals the input header unchanged.
- R10: A clock edge with `tbl_we` high writes all fields of entry `tbl_addr`, including its valid flag. Writing valid low removes the entry from the search.
- R11: Reset leaves `out_valid` low and every table entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header can be taken |
| in_hdr | input | 160 | IPv4 header, first byte in bits [159:152] |
| in_frame_len | input | 16 | Frame length in bytes |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_verdict | output | 2 | 00 forward, 01 drop, 10 CPU |
| out_ports | output | 4 | Output port bitmap |
| out_next_hop | output | 32 | Next-hop address |
| out_hdr | output | 160 | Rewritten or original header |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 3 | Entry index |
| tbl_valid | input | 1 | Valid flag to write |
| tbl_prefix | input | 32 | Prefix to write |
| tbl_mask | input | 32 | Mask to write |
| tbl_next_hop | input | 32 | Next hop to write |
| tbl_ports | input | 4 | Port bitmap to write |

## Verification
The prefix search is exercised with destinations that match a /24, a /16 and a /8 route nested inside each other, so that a wrong preference order returns a different port. Two identical /16 routes separate lowest-index tie breaking from highest-index tie breaking. An unrelated /16 and an unmatched address show that masks are applied per entry and that a miss is handled.

Headers that break several rules at once, such as a bad checksum combined with a short frame and TTL 1, show which rule takes precedence. Lengths of 63, 64, 1500 and 1501 and TTLs of 0, 1 and 2 pin each boundary.

Later table writes add a default route and invalidate a /24 entry, which shows that software updates reach the search. A stall of the consumer checks that the outputs hold and that the next header waits.

// File: rtl/ipv4_fwd_pkg.sv
package ipv4_fwd_pkg;

  localparam int HDR_W = 160;

  typedef enum logic [1:0] {
    VERD_FWD  = 2'b00,
    VERD_DROP = 2'b01,
    VERD_CPU  = 2'b10
  } verdict_e;

  // field positions in the 160-bit header (first byte at the top)
  localparam int VER_HI  = 159;
  localparam int IHL_HI  = 155;
  localparam int TTL_HI  = 95;
  localparam int CSUM_HI = 79;
  localparam int DST_HI  = 31;

  // fold a wide sum into a 16-bit ones'-complement sum
  function automatic logic [15:0] oc_fold(input logic [31:0] s);
    logic [31:0] t;
    t = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return t[15:0];
  endfunction

endpackage

// File: rtl/ipv4_hdr_check.sv
module ipv4_hdr_check
  import ipv4_fwd_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1500
) (
  input  logic [HDR_W-1:0] hdr,
  input  logic [LEN_W-1:0] frame_len,
  output logic             csum_ok,
  output logic             len_ok,
  output logic             fmt_ok,
  output logic             ttl_ok
);
  localparam int NWORDS = HDR_W / 16;

  logic [31:0] wsum;

  always_comb begin
    wsum = '0;
    for (int w = 0; w < NWORDS; w++) begin
      wsum = wsum + {16'h0, hdr[w*16 +: 16]};
    end
    csum_ok = (oc_fold(wsum) == 16'hFFFF);
    len_ok  = (frame_len >= LEN_W'(MIN_LEN)) && (frame_len <= LEN_W'(MAX_LEN));
    fmt_ok  = (hdr[VER_HI -: 4] == 4'd4) && (hdr[IHL_HI -: 4] == 4'd5);
    ttl_ok  = (hdr[TTL_HI -: 8] > 8'd1);
  end

endmodule

// File: rtl/ipv4_route_table.sv
module ipv4_route_table #(
  parameter int N_ENTRIES = 8,
  parameter int N_PORTS   = 4,
  localparam int AW       = $clog2(N_ENTRIES),
  localparam int LW       = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic               wr_valid,
  input  logic [31:0]        wr_prefix,
  input  logic [31:0]        wr_mask,
  input  logic [31:0]        wr_next_hop,
  input  logic [N_PORTS-1:0] wr_ports,
  input  logic [31:0]        dst,
  output logic               hit,
  output logic [31:0]        hit_next_hop,
  output logic [N_PORTS-1:0] hit_ports
);
  logic [N_ENTRIES-1:0] vld_q, vld_d;
  logic [31:0]          pfx_q [N_ENTRIES];
  logic [31:0]          msk_q [N_ENTRIES];
  logic [31:0]          nh_q  [N_ENTRIES];
  logic [N_PORTS-1:0]   prt_q [N_ENTRIES];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_addr] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  generate
    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
        if (wr_en && (wr_addr == AW'(e))) begin
          pfx_q[e] <= wr_prefix;
          msk_q[e] <= wr_mask;
          nh_q[e]  <= wr_next_hop;
          prt_q[e] <= wr_ports;
        end
      end
    end
  endgenerate

  logic [AW-1:0] best;
  logic [LW-1:0] best_len;
  logic [LW-1:0] cur_len;

  always_comb begin
    hit      = 1'b0;
    best     = '0;
    best_len = '0;
    cur_len  = '0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      cur_len = LW'($countones(msk_q[e]));
      if (vld_q[e] && ((dst & msk_q[e]) == (pfx_q[e] & msk_q[e]))
          && (!hit || (cur_len > best_len))) begin
        hit      = 1'b1;
        best     = AW'(e);
        best_len = cur_len;
      end
    end
    hit_next_hop = nh_q[best];
    hit_ports    = prt_q[best];
  end

endmodule

// File: rtl/ipv4_ttl_rewrite.sv
module ipv4_ttl_rewrite
  import ipv4_fwd_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_in,
  output logic [HDR_W-1:0] hdr_out
);
  logic [15:0] old_w, new_w, old_c;
  logic [31:0] acc;

  always_comb begin
    old_w = hdr_in[TTL_HI -: 16];
    new_w = {hdr_in[TTL_HI -: 8] - 8'd1, hdr_in[TTL_HI-8 -: 8]};
    old_c = hdr_in[CSUM_HI -: 16];
    // new checksum = ~(~old_csum + ~old_word + new_word), ones'-complement
    acc   = {16'h0, ~old_c} + {16'h0, ~old_w} + {16'h0, new_w};
    hdr_out = hdr_in;
    hdr_out[TTL_HI -: 16]  = new_w;
    hdr_out[CSUM_HI -: 16] = ~oc_fold(acc);
  end

endmodule

// File: rtl/ipv4_fwd_engine.sv
module ipv4_fwd_engine
  import ipv4_fwd_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int N_PORTS   = 4,
  parameter int LEN_W     = 16,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1500,
  localparam int AW       = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [HDR_W-1:0]   in_hdr,
  input  logic [LEN_W-1:0]   in_frame_len,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_verdict,
  output logic [N_PORTS-1:0] out_ports,
  output logic [31:0]        out_next_hop,
  output logic [HDR_W-1:0]   out_hdr,
  input  logic               tbl_we,
  input  logic [AW-1:0]      tbl_addr,
  input  logic               tbl_valid,
  input  logic [31:0]        tbl_prefix,
  input  logic [31:0]        tbl_mask,
  input  logic [31:0]        tbl_next_hop,
  input  logic [N_PORTS-1:0] tbl_ports
);
  logic csum_ok, len_ok, fmt_ok, ttl_ok;
  logic rt_hit;
  logic [31:0]        rt_nh;
  logic [N_PORTS-1:0] rt_ports;
  logic [HDR_W-1:0]   hdr_dec;

  ipv4_hdr_check #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_check (
    .hdr(in_hdr), .frame_len(in_frame_len),
    .csum_ok(csum_ok), .len_ok(len_ok), .fmt_ok(fmt_ok), .ttl_ok(ttl_ok)
  );

  ipv4_route_table #(.N_ENTRIES(N_ENTRIES), .N_PORTS(N_PORTS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_valid(tbl_valid),
    .wr_prefix(tbl_prefix), .wr_mask(tbl_mask),
    .wr_next_hop(tbl_next_hop), .wr_ports(tbl_ports),
    .dst(in_hdr[DST_HI -: 32]),
    .hit(rt_hit), .hit_next_hop(rt_nh), .hit_ports(rt_ports)
  );

  ipv4_ttl_rewrite u_rewrite (.hdr_in(in_hdr), .hdr_out(hdr_dec));

  verdict_e           verd_d;
  logic               accept;
  logic               vld_d;
  logic [N_PORTS-1:0] ports_d;
  logic [31:0]        nh_d;
  logic [HDR_W-1:0]   hdr_d;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (!csum_ok)     verd_d = VERD_DROP;
    else if (!len_ok) verd_d = VERD_DROP;
    else if (!fmt_ok) verd_d = VERD_CPU;
    else if (!ttl_ok) verd_d = VERD_CPU;
    else if (!rt_hit) verd_d = VERD_CPU;
    else              verd_d = VERD_FWD;

    if (verd_d == VERD_FWD) begin
      ports_d = rt_ports;
      nh_d    = rt_nh;
      hdr_d   = hdr_dec;
    end else begin
      ports_d = '0;
      nh_d    = '0;
      hdr_d   = in_hdr;
    end

    vld_d = accept ? 1'b1 : (out_ready ? 1'b0 : out_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_verdict  <= verd_d;
      out_ports    <= ports_d;
      out_next_hop <= nh_d;
      out_hdr      <= hdr_d;
    end
  end

endmodule

// File: rtl/ipv4_fwd_checker.sv
module ipv4_fwd_checker #(
  parameter int N_PORTS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [1:0]         out_verdict,
  input logic [N_PORTS-1:0] out_ports,
  input logic [31:0]        out_next_hop,
  input logic [159:0]       out_hdr
);
  logic [31:0] osum;
  logic [15:0] ofold;

  always_comb begin
    osum = '0;
    for (int w = 0; w < 10; w++) osum = osum + {16'h0, out_hdr[w*16 +: 16]};
    osum  = {16'h0, osum[15:0]} + {16'h0, osum[31:16]};
    ofold = osum[15:0] + {15'h0, osum[16]};
  end

  wire is_fwd = out_valid && (out_verdict == 2'b00);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_verdict) &&
      $stable(out_ports) && $stable(out_next_hop) && $stable(out_hdr)));

  assert_rise_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_verdict != 2'b11));

  assert_fwd_format_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_fwd |-> (out_hdr[159:152] == 8'h45));

  assert_fwd_ttl_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_fwd |-> (out_hdr[95:88] != 8'd0));

  assert_fwd_csum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_fwd |-> (ofold == 16'hFFFF));

  assert_nofwd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_fwd) |-> ((out_ports == '0) && (out_next_hop == 32'h0)));

endmodule

bind ipv4_fwd_engine ipv4_fwd_checker #(.N_PORTS(N_PORTS)) u_fwd_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_verdict(out_verdict),
  .out_ports(out_ports), .out_next_hop(out_next_hop), .out_hdr(out_hdr)
);

// File: tb/ipv4_fwd_engine_bench.sv
module ipv4_fwd_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [159:0] in_hdr = '0;
  logic [15:0] in_frame_len = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_verdict;
  logic [3:0] out_ports;
  logic [31:0] out_next_hop;
  logic [159:0] out_hdr;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_addr = '0;
  logic tbl_valid = 1'b0;
  logic [31:0] tbl_prefix = '0, tbl_mask = '0, tbl_next_hop = '0;
  logic [3:0] tbl_ports = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipv4_fwd_engine u_ipv4_fwd_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_frame_len(in_frame_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_verdict(out_verdict), .out_ports(out_ports),
    .out_next_hop(out_next_hop), .out_hdr(out_hdr), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_valid(tbl_valid), .tbl_prefix(tbl_prefix),
    .tbl_mask(tbl_mask), .tbl_next_hop(tbl_next_hop), .tbl_ports(tbl_ports)
  );

  typedef struct packed {
    logic [3:0]  ver;
    logic [3:0]  ihl;
    logic [7:0]  ttl;
    logic [31:0] dst;
    logic [15:0] flen;
    logic        bad;
    logic [1:0]  ev;
    logic [3:0]  ep;
    logic [31:0] enh;
  } vec_t;

  localparam logic [1:0] FWD = 2'b00, DRP = 2'b01, CPU = 2'b10;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd200,  1'b0, FWD, 4'b0100, 32'h0A010201}, // R6 /24
    '{4'd4, 4'd5, 8'd64, 32'h0A010909, 16'd200,  1'b0, FWD, 4'b0010, 32'h0A010001}, // R6 /16 tie low idx
    '{4'd4, 4'd5, 8'd64, 32'h0AC80001, 16'd200,  1'b0, FWD, 4'b0001, 32'h0A000001}, // R6 /8
    '{4'd4, 4'd5, 8'd9,  32'hC0A80303, 16'd500,  1'b0, FWD, 4'b1000, 32'hC0A80001}, // R8 other /16
    '{4'd4, 4'd5, 8'd64, 32'h08080808, 16'd200,  1'b0, CPU, 4'b0000, 32'h0},        // R7 miss
    '{4'd4, 4'd5, 8'd1,  32'h0A010205, 16'd200,  1'b0, CPU, 4'b0000, 32'h0},        // R5 ttl 1
    '{4'd4, 4'd5, 8'd0,  32'h0A010205, 16'd200,  1'b0, CPU, 4'b0000, 32'h0},        // R5 ttl 0
    '{4'd4, 4'd5, 8'd2,  32'h0A010205, 16'd200,  1'b0, FWD, 4'b0100, 32'h0A010201}, // R5 ttl 2
    '{4'd6, 4'd5, 8'd64, 32'h0A010205, 16'd200,  1'b0, CPU, 4'b0000, 32'h0},        // R4 version
    '{4'd4, 4'd6, 8'd64, 32'h0A010205, 16'd200,  1'b0, CPU, 4'b0000, 32'h0},        // R4 options
    '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd63,   1'b0, DRP, 4'b0000, 32'h0},        // R3 63
    '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd64,   1'b0, FWD, 4'b0100, 32'h0A010201}, // R3 64
    '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd1500, 1'b0, FWD, 4'b0100, 32'h0A010201}, // R3 1500
    '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd1501, 1'b0, DRP, 4'b0000, 32'h0},        // R3 1501
    '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd200,  1'b1, DRP, 4'b0000, 32'h0},        // R2 bad csum
    '{4'd4, 4'd5, 8'd1,  32'h0A010205, 16'd63,   1'b1, DRP, 4'b0000, 32'h0},        // R2 outranks all
    '{4'd6, 4'd5, 8'd64, 32'h0A010205, 16'd1501, 1'b0, DRP, 4'b0000, 32'h0},        // R3 over R4
    '{4'd6, 4'd5, 8'd1,  32'h08080808, 16'd200,  1'b0, CPU, 4'b0000, 32'h0}         // R4 over R5/R7
  };

  function automatic logic [159:0] mk_hdr(input logic [3:0] ver, input logic [3:0] ihl,
      input logic [7:0] ttl, input logic [31:0] dst, input logic [15:0] flen, input logic bad);
    logic [159:0] h;
    logic [31:0] s;
    h = {ver, ihl, 8'h00, flen - 16'd14, 16'h1C46, 16'h4000, ttl, 8'h06, 16'h0000,
         32'hC0A80A01, dst};
    s = '0;
    for (int w = 0; w < 10; w++) s = s + {16'h0, h[w*16 +: 16]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    h[79:64] = ~s[15:0] ^ {15'h0, bad};
    return h;
  endfunction

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_entry(input int idx, input logic v, input logic [31:0] p,
      input logic [31:0] m, input logic [31:0] nh, input logic [3:0] pt);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 3'(idx); tbl_valid = v;
    tbl_prefix = p; tbl_mask = m; tbl_next_hop = nh; tbl_ports = pt;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_vec(input string req, input vec_t v);
    logic [159:0] h, eh;
    h = mk_hdr(v.ver, v.ihl, v.ttl, v.dst, v.flen, v.bad);
    eh = (v.ev == FWD) ? mk_hdr(v.ver, v.ihl, v.ttl - 8'd1, v.dst, v.flen, 1'b0) : h;
    @(negedge clk);
    in_valid = 1'b1; in_hdr = h; in_frame_len = v.flen;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid R1"}, {159'h0, out_valid}, 160'h1);
    check({req, " verdict"}, {158'h0, out_verdict}, {158'h0, v.ev});
    check({req, " ports R8/R9"}, {156'h0, out_ports}, {156'h0, v.ep});
    check({req, " next hop R8/R9"}, {128'h0, out_next_hop}, {128'h0, v.enh});
    check({req, " header R8/R9"}, out_hdr, eh);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t t;
    repeat (3) @(negedge clk);
    // R11: reset state, out_valid low and empty table
    check("R11 out_valid in reset", {159'h0, out_valid}, 160'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {159'h0, out_valid}, 160'h0);
    check("R1 in_ready idle", {159'h0, in_ready}, 160'h1);
    t = '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd200, 1'b0, CPU, 4'b0, 32'h0};
    run_vec("R11 empty table miss", t);

    // R10: program table
    wr_entry(0, 1'b1, 32'h0A000000, 32'hFF000000, 32'h0A000001, 4'b0001);
    wr_entry(1, 1'b1, 32'h0A010000, 32'hFFFF0000, 32'h0A010001, 4'b0010);
    wr_entry(2, 1'b1, 32'h0A010200, 32'hFFFFFF00, 32'h0A010201, 4'b0100);
    wr_entry(5, 1'b1, 32'hC0A80000, 32'hFFFF0000, 32'hC0A80001, 4'b1000);
    wr_entry(6, 1'b1, 32'h0A010000, 32'hFFFF0000, 32'h0A0100FE, 4'b0011);

    for (int i = 0; i < NV; i++) run_vec($sformatf("vec%0d", i), VECS[i]);

    // R7: add default route, unmatched address now forwards
    wr_entry(3, 1'b1, 32'h0, 32'h0, 32'hC0A800FE, 4'b1001);
    t = '{4'd4, 4'd5, 8'd64, 32'h08080808, 16'd200, 1'b0, FWD, 4'b1001, 32'hC0A800FE};
    run_vec("R7 default route", t);
    t = '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd200, 1'b0, FWD, 4'b0100, 32'h0A010201};
    run_vec("R6 default loses to /24", t);

    // R10: invalidate the /24, falls back to /16 entry 1
    wr_entry(2, 1'b0, 32'h0A010200, 32'hFFFFFF00, 32'h0A010201, 4'b0100);
    t = '{4'd4, 4'd5, 8'd64, 32'h0A010205, 16'd200, 1'b0, FWD, 4'b0010, 32'h0A010001};
    run_vec("R10 invalidated entry", t);

    // R1: backpressure holds output and stalls the next header
    begin
      logic [159:0] ha, hb;
      ha = mk_hdr(4'd4, 4'd5, 8'd64, 32'h0AC80001, 16'd200, 1'b0);
      hb = mk_hdr(4'd4, 4'd5, 8'd64, 32'h08080808, 16'd300, 1'b1);
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_hdr = ha; in_frame_len = 16'd200;
      @(negedge clk);
      in_hdr = hb; in_frame_len = 16'd300;
      repeat (3) @(negedge clk);
      check("R1 held valid", {159'h0, out_valid}, 160'h1);
      check("R1 stalled ready", {159'h0, in_ready}, 160'h0);
      check("R1 held ports", {156'h0, out_ports}, {156'h0, 4'b0001});
      check("R1 held header", out_hdr,
            mk_hdr(4'd4, 4'd5, 8'd63, 32'h0AC80001, 16'd200, 1'b0));
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 next verdict", {158'h0, out_verdict}, {158'h0, DRP});
      check("R2 stalled header unchanged", out_hdr, hb);
      @(negedge clk);
      check("R1 drains", {159'h0, out_valid}, 160'h0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule